// File: doc/BRIEF.md
# Masked Truth-Table Fitness Accumulator

This block scores a candidate logic circuit against a target truth table. Each input beat carries one word of the circuit's actual outputs, the matching word of desired outputs and a validity mask word. Each bit is one truth-table row of one output. A position whose mask bit is 0 is a don't-care and always counts as correct. The block counts the matching bits of each beat and adds them up over every row block of every output. When the final beat arrives it reports the total, a flag that says whether every bit matched, and a score. For a perfect circuit the score adds the number of redundant nodes, so that a search keeps favouring smaller circuits.

In extended mode a two-bit gene comes with each don't-care position of a word. The gene either pins the desired bit to 0 or 1, making the position a fixed one, or leaves it free. The desired word and the mask are rebuilt from the genes on every beat, before the comparison. Beats are streamed output by output. Within one output the row blocks arrive in ascending order. Rows past the end of the table in an output's last block are never counted.

Top module: `fitness_accum`

## Requirements
- R1: A cycle with `start_i` high clears the running count, and in the next cycle `fitness_o`, `score_o`, `perfect_o` and `done_o` read 0. A beat presented in that same cycle is dropped.
- R2: A fixed position (effective mask bit 1) counts as correct only when the actual bit equals the effective desired bit.
- R3: With `ext_mode_i` low, a position whose mask bit is 0 counts as correct, whatever the actual and desired bits are.
- R4: Bit i of row block b stands for row b*WORD_W+i. Rows at or above NUM_ROWS never count, whatever the data there.
- R5: In extended mode, gene code 0 turns a don't-care into a fixed position with desired bit 0, and gene code 1 does the same with desired bit 1.
- R6: In extended mode, gene codes 2 and 3 both leave the position a don't-care that counts as correct.
- R7: Within a word, the k-th don't-care counted from bit 0 upward uses gene bits [2k+1:2k]. Fixed positions consume no gene, and the genes have no effect when the mask is all ones.
- R8: When the beat with `in_last_i` is accepted at clock edge n, `done_o` is high for exactly the cycle after edge n+1. `fitness_o` then holds the total count of correct bits of that evaluation, and the count restarts from zero for the next one.
- R9: `perfect_o` is high after a final beat exactly when the total equals NUM_ROWS*NUM_OUTS. It holds until the next final beat or start.
- R10: `score_o` equals NUM_ROWS*NUM_OUTS plus the `redund_i` value sampled with the final beat when the result is perfect, and equals `fitness_o` otherwise.
- R11: Cycles with `in_valid_i` low leave the count unchanged, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new evaluation, clears count and results |
| ext_mode_i | input | 1 | 1: rebuild desired word and mask from genes |
| in_valid_i | input | 1 | Beat present on the data inputs |
| in_last_i | input | 1 | Beat is the final one of the evaluation |
| act_i | input | WORD_W | Actual circuit outputs, one row per bit |
| des_i | input | WORD_W | Desired outputs |
| mask_i | input | WORD_W | 1 = fixed row, 0 = don't-care |
| gene_i | input | 2*WORD_W | Two-bit genes for the word's don't-cares, lowest first |
| redund_i | input | $clog2(NUM_NODES+1) | Redundant node count, sampled with the final beat |
| done_o | output | 1 | One-cycle result strobe |
| fitness_o | output | $clog2(NUM_ROWS*NUM_OUTS+1) | Total correct bits |
| perfect_o | output | 1 | Every bit of the table correct |
| score_o | output | $clog2(NUM_ROWS*NUM_OUTS+NUM_NODES+1) | Fitness, or maximum plus redundancy when perfect |

## Verification
Some properties are checked on every cycle. Don't-care rows inside the table always produce a match bit. Genes never turn a fixed position back into a don't-care. The running count never passes the table's maximum. A perfect flag always comes with a full fitness, and an imperfect score always equals the fitness. A start always leaves cleared results behind it. Other behaviour shows only in the bench's sweeps over random and directed tables: the exact totals, the gene ordering over don't-cares, the masking of tail rows, the dropped beat under start and the exact strobe cycle.

// File: rtl/fit_pkg.sv
package fit_pkg;
  typedef enum logic [1:0] {
    GENE_ZERO = 2'd0,
    GENE_ONE  = 2'd1,
    GENE_FREE = 2'd2,
    GENE_RSVD = 2'd3
  } gene_e;
endpackage

// File: rtl/fit_word_cmp.sv
module fit_word_cmp #(
  parameter int WORD_W = 32,
  parameter int ND_W   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                ext_i,
  input  logic                valid_i,
  input  logic                last_i,
  input  logic [WORD_W-1:0]   act_i,
  input  logic [WORD_W-1:0]   des_i,
  input  logic [WORD_W-1:0]   mask_i,
  input  logic [2*WORD_W-1:0] gene_i,
  input  logic [WORD_W-1:0]   row_ok_i,
  input  logic [ND_W-1:0]     redund_i,
  output logic                v_q,
  output logic                last_q,
  output logic [WORD_W-1:0]   match_q,
  output logic [ND_W-1:0]     redund_q
);
  import fit_pkg::*;

  // Returns {desired, mask} after the genes are applied to the don't-cares.
  function automatic logic [2*WORD_W-1:0] apply_genes(
    input logic [WORD_W-1:0]   d,
    input logic [WORD_W-1:0]   m,
    input logic [2*WORD_W-1:0] g
  );
    logic [WORD_W-1:0] dn, mn;
    gene_e gc;
    int k;
    dn = d;
    mn = m;
    k  = 0;
    for (int i = 0; i < WORD_W; i++) begin
      if (!m[i]) begin
        gc = gene_e'(g[2*k +: 2]);
        case (gc)
          GENE_ZERO: begin dn[i] = 1'b0; mn[i] = 1'b1; end
          GENE_ONE:  begin dn[i] = 1'b1; mn[i] = 1'b1; end
          default:   begin dn[i] = d[i]; mn[i] = 1'b0; end
        endcase
        k = k + 1;
      end
    end
    return {dn, mn};
  endfunction

  logic [WORD_W-1:0] des_eff, mask_eff, match_d;
  logic              fire;

  assign fire = valid_i && !start_i;

  always_comb begin
    if (ext_i) {des_eff, mask_eff} = apply_genes(des_i, mask_i, gene_i);
    else       {des_eff, mask_eff} = {des_i, mask_i};
    match_d = ~((act_i & mask_eff) ^ (des_eff & mask_eff)) & row_ok_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q      <= 1'b0;
      last_q   <= 1'b0;
      match_q  <= '0;
      redund_q <= '0;
    end else begin
      v_q    <= fire;
      last_q <= fire && last_i;
      if (fire) begin
        match_q  <= match_d;
        redund_q <= redund_i;
      end
    end
  end

  // R3/R6: every in-table don't-care row yields a match bit
  a_r3_dc_match: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> ((~mask_eff & row_ok_i & ~match_d) == '0));

  // R5: genes only ever add fixed positions, never remove them
  a_r5_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ext_i) |-> ((mask_eff & mask_i) == mask_i));
endmodule

// File: rtl/fit_popcnt_acc.sv
module fit_popcnt_acc #(
  parameter int WORD_W  = 32,
  parameter int MAX_FIT = 64,
  parameter int CNT_W   = 7,
  parameter int ND_W    = 7,
  parameter int SC_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              v_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] match_i,
  input  logic [ND_W-1:0]   redund_i,
  output logic              done_o,
  output logic [CNT_W-1:0]  fitness_o,
  output logic              perfect_o,
  output logic [SC_W-1:0]   score_o
);
  localparam int PC_W = $clog2(WORD_W + 1);

  function automatic logic [PC_W-1:0] ones(input logic [WORD_W-1:0] v);
    logic [PC_W-1:0] c;
    c = '0;
    for (int i = 0; i < WORD_W; i++) c = c + PC_W'(v[i]);
    return c;
  endfunction

  logic [CNT_W-1:0] acc_q, acc_next;
  logic [PC_W-1:0]  word_hits;
  logic             full_hit;

  assign word_hits = ones(match_i);
  assign acc_next  = acc_q + CNT_W'(word_hits);
  assign full_hit  = (acc_next == CNT_W'(MAX_FIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; done_o <= 1'b0; fitness_o <= '0;
      perfect_o <= 1'b0; score_o <= '0;
    end else if (start_i) begin
      acc_q <= '0; done_o <= 1'b0; fitness_o <= '0;
      perfect_o <= 1'b0; score_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (v_i) begin
        if (last_i) begin
          acc_q     <= '0;
          done_o    <= 1'b1;
          fitness_o <= acc_next;
          perfect_o <= full_hit;
          score_o   <= full_hit ? SC_W'(MAX_FIT) + SC_W'(redund_i)
                                : SC_W'(acc_next);
        end else begin
          acc_q <= acc_next;
        end
      end
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(acc_q) <= MAX_FIT);

  a_r9_perfect_full: assert property (@(posedge clk) disable iff (!rst_n)
    perfect_o |-> (int'(fitness_o) == MAX_FIT));

  a_r10_score_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !perfect_o) |-> (score_o == SC_W'(fitness_o)));

  a_r1_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (fitness_o == '0 && score_o == '0 && !perfect_o && !done_o));
endmodule

// File: rtl/fitness_accum.sv
module fitness_accum #(
  parameter int WORD_W    = 32,
  parameter int NUM_ROWS  = 16,
  parameter int NUM_OUTS  = 4,
  parameter int NUM_NODES = 100,
  localparam int MAX_FIT  = NUM_ROWS * NUM_OUTS,
  localparam int BLOCKS   = (NUM_ROWS + WORD_W - 1) / WORD_W,
  localparam int BLK_W    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int ND_W     = $clog2(NUM_NODES + 1),
  localparam int CNT_W    = $clog2(MAX_FIT + 1),
  localparam int SC_W     = $clog2(MAX_FIT + NUM_NODES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                ext_mode_i,
  input  logic                in_valid_i,
  input  logic                in_last_i,
  input  logic [WORD_W-1:0]   act_i,
  input  logic [WORD_W-1:0]   des_i,
  input  logic [WORD_W-1:0]   mask_i,
  input  logic [2*WORD_W-1:0] gene_i,
  input  logic [ND_W-1:0]     redund_i,
  output logic                done_o,
  output logic [CNT_W-1:0]    fitness_o,
  output logic                perfect_o,
  output logic [SC_W-1:0]     score_o
);
  function automatic logic [WORD_W-1:0] rows_in_table(input int blk);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = (blk * WORD_W + i) < NUM_ROWS;
    return r;
  endfunction

  logic [BLK_W-1:0]  blk_q;
  logic [WORD_W-1:0] row_ok;
  logic              word_fire, blk_wrap;
  logic              v_s1, last_s1;
  logic [WORD_W-1:0] match_s1;
  logic [ND_W-1:0]   redund_s1;

  assign word_fire = in_valid_i && !start_i;
  assign blk_wrap  = in_last_i || (int'(blk_q) == BLOCKS - 1);
  assign row_ok    = rows_in_table(int'(blk_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         blk_q <= '0;
    else if (start_i)   blk_q <= '0;
    else if (word_fire) blk_q <= blk_wrap ? '0 : blk_q + 1'b1;
  end

  a_r4_blk_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(blk_q) < BLOCKS);

  fit_word_cmp #(.WORD_W(WORD_W), .ND_W(ND_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_i(ext_mode_i),
    .valid_i(in_valid_i), .last_i(in_last_i), .act_i(act_i), .des_i(des_i),
    .mask_i(mask_i), .gene_i(gene_i), .row_ok_i(row_ok), .redund_i(redund_i),
    .v_q(v_s1), .last_q(last_s1), .match_q(match_s1), .redund_q(redund_s1)
  );

  fit_popcnt_acc #(.WORD_W(WORD_W), .MAX_FIT(MAX_FIT), .CNT_W(CNT_W),
                   .ND_W(ND_W), .SC_W(SC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .v_i(v_s1),
    .last_i(last_s1), .match_i(match_s1), .redund_i(redund_s1),
    .done_o(done_o), .fitness_o(fitness_o), .perfect_o(perfect_o),
    .score_o(score_o)
  );
endmodule

// File: tb/tb_fitness_accum.sv
module tb_fitness_accum;
  localparam int W = 32, ROWS = 40, OUTS = 3, NODES = 20;
  localparam int BLKS = (ROWS + W - 1) / W;
  localparam int MAXF = ROWS * OUTS;

  logic clk = 0, rst_n = 0, start = 0, ext = 0, vld = 0, lst = 0;
  logic [W-1:0] act = '0, des = '0, msk = '0;
  logic [2*W-1:0] gen = '0;
  logic [4:0] red = '0;
  logic done, perf;
  logic [6:0] fit;
  logic [7:0] score;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  fitness_accum #(.WORD_W(W), .NUM_ROWS(ROWS), .NUM_OUTS(OUTS), .NUM_NODES(NODES)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ext_mode_i(ext),
    .in_valid_i(vld), .in_last_i(lst), .act_i(act), .des_i(des), .mask_i(msk),
    .gene_i(gen), .redund_i(red), .done_o(done), .fitness_o(fit),
    .perfect_o(perf), .score_o(score));

  task automatic chk(input bit ok, input string req, input int a, input int e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  // independent scoring of one word
  function automatic int model(input logic [W-1:0] a, d, m, input logic [2*W-1:0] g,
                               input bit e, input int blk);
    int c = 0, k = 0;
    for (int i = 0; i < W; i++) begin
      bit fx = m[i], dv = d[i];
      if (blk * W + i >= ROWS) continue;
      if (e && !fx) begin
        int code = int'(g[2*k +: 2]);
        k++;
        if (code == 0) begin fx = 1; dv = 0; end
        else if (code == 1) begin fx = 1; dv = 1; end
      end
      if (!fx || a[i] == dv) c++;
    end
    return c;
  endfunction

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  // pat: 0 random, 1 act matches des, 2 all fixed and all wrong, 3 diffs only past table end
  // gm: 0..3 constant gene code, 4 random genes
  task automatic run_eval(input int pat, input bit e, input int gm, input bit gaps, input string req);
    int exp = 0, exp_sc;
    logic [4:0] r = 5'($urandom_range(0, NODES));
    for (int o = 0; o < OUTS; o++)
      for (int b = 0; b < BLKS; b++) begin
        logic [W-1:0] d = $urandom(), m = $urandom(), a = $urandom();
        logic [2*W-1:0] g = {$urandom(), $urandom()};
        if (pat == 1) a = (d & m) | (a & ~m);
        if (pat == 2) begin m = '1; a = ~d; end
        if (pat == 3) begin
          m = '1;
          for (int i = 0; i < W; i++) if (b * W + i < ROWS) a[i] = d[i];
        end
        if (gm < 4) for (int k = 0; k < W; k++) g[2*k +: 2] = 2'(gm);
        exp += model(a, d, m, g, e, b);
        @(negedge clk);
        vld = 1; act = a; des = d; msk = m; gen = g; ext = e; red = r;
        lst = (o == OUTS - 1) && (b == BLKS - 1);
        if (gaps && !lst) begin
          @(negedge clk); vld = 0; act = ~act; msk = ~msk; lst = 1;
        end
      end
    @(posedge clk);
    @(negedge clk); vld = 0; lst = 0; act = $urandom(); red = ~red;
    chk(done == 0, "R8 early strobe", int'(done), 0);
    @(negedge clk);
    exp_sc = (exp == MAXF) ? MAXF + int'(r) : exp;
    chk(done == 1, "R8 strobe", int'(done), 1);
    chk(int'(fit) == exp, req, int'(fit), exp);
    chk(perf == (exp == MAXF), "R9 perfect", int'(perf), int'(exp == MAXF));
    chk(int'(score) == exp_sc, "R10 score", int'(score), exp_sc);
    @(negedge clk);
    chk(done == 0, "R8 single strobe", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0 && fit == 0 && perf == 0 && score == 0, "R1 reset", int'(fit), 0);

    run_eval(1, 0, 0, 0, "R3 perfect simple");
    run_eval(2, 0, 0, 0, "R2 all wrong");
    run_eval(3, 0, 0, 0, "R4 tail rows");
    for (int n = 0; n < 20; n++) run_eval(0, 0, 0, n[0], "R2 R3 R11 random");
    run_eval(0, 1, 0, 0, "R5 gene zero");
    run_eval(0, 1, 1, 0, "R5 gene one");
    run_eval(1, 1, 2, 0, "R6 gene free");
    run_eval(1, 1, 3, 1, "R6 gene reserved");
    for (int n = 0; n < 30; n++) run_eval(0, 1, 4, n[0], "R7 random genes");
    run_eval(2, 1, 4, 0, "R7 genes ignored when fixed");
    run_eval(1, 1, 4, 0, "R7 genes on matching data");

    // R1: start drops a concurrent beat and discards a partial evaluation
    @(negedge clk); vld = 1; lst = 0; ext = 0; msk = '1; des = $urandom(); act = des;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; vld = 0;
    chk(fit == 0 && perf == 0 && done == 0, "R1 start clear", int'(fit), 0);
    run_eval(1, 0, 0, 0, "R1 R11 fresh after start");
    do_start();
    chk(fit == 0 && score == 0 && perf == 0, "R1 clear after result", int'(score), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule